// File: doc/BRIEF.md
# SD Card Clock Divider Control

This block derives the card-side clock of an SD host from the master clock. It has a small write/read configuration port. The stored word holds a sparse divider selector, an output-enable bit and an automatic-stop bit. The divided clock is produced as a registered level in the master clock domain. Two single-cycle strobes go with it: one marks each rising edge and one marks each falling edge. The card-side shift logic can launch and capture data on these strobes without a second clock domain.

A busy input from the command/data engine tells the block when the bus carries traffic. With automatic stop enabled, the card clock runs only while busy is high. When the bus goes quiet, the clock parks low. Starting and stopping happen only while the divided level is low, so the card never sees a shortened high pulse. While the output is enabled, the divider cannot be changed, so software has to disable the clock before it picks a new rate.

Top module: `sdclk_gen`

## Requirements
- R1: After synchronous reset the read-back word is 0x0000_0080 (divide-by-512 selected, enable and auto-stop clear). The card clock level and both strobes are low.
- R2: Divider selector decoding. Bit k of the low byte (k = 0..7) selects division by 2^(k+2). An all-zero selector selects division by 2. Bit 16 selects division by 1024. While the clock is enabled, successive rise strobes are exactly that many master cycles apart.
- R3: For every divisor N of 2 or more, the card clock level is high for exactly N/2 master cycles of each period, and every rise of the level is flagged by the rise strobe in the same cycle.
- R4: If more than one selector bit is set, the largest selected divisor is used. Bit 10 counts as divisor 1.
- R5: With only bit 10 set (bypass), the rise and fall strobes are both high in every master cycle while the clock runs, and the level output stays low.
- R6: A write leaves the selector unchanged when the stored enable bit (bit 8) was already set before that write. This includes a write that clears the enable bit. The enable and auto-stop bits are always taken from the write.
- R7: Clearing enable stops the clock only in a low phase. A high phase that is in progress completes at its full length, after which no further strobes occur and the level stays low.
- R8: With auto-stop (bit 9) and enable set, the clock runs only while busy is high. After busy falls, the level is low within one divided period and no further rise strobe occurs. The next busy assertion restarts the clock.
- R9: When the divide-by-1024 capability parameter is 0, bit 16 is not stored, reads back 0 and has no effect on the divisor.
- R10: Read-back returns the stored selector bits (16, 10, 7:0), enable (8) and auto-stop (9). All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe for the configuration word |
| wr_data_i | input | 17 | Configuration data to write |
| rd_data_o | output | 32 | Read-back of the configuration word |
| busy_i | input | 1 | Bus in use by the command/data engine |
| card_clk_o | output | 1 | Divided card clock level |
| card_rise_o | output | 1 | One-cycle strobe on each card clock rising edge |
| card_fall_o | output | 1 | One-cycle strobe on each card clock falling edge |

## Verification
Two functions can land in the same cycle: a stop request and a period boundary. A stop request comes from busy falling or from enable being cleared. A write can also clear enable and change the selector at once. The bench drops busy at the cycle of a fall strobe and expects no later rise. It clears enable while the level is high and expects the full high length of N/2. It writes a new selector together with the enable clear and expects the old selector to read back.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

    // Width of the write port (selector reaches bit 16)
    localparam int FIELD_W  = 17;
    // Largest divider exponent (divide by 1024)
    localparam int LOG_MAX  = 10;
    localparam int LOG_W    = $clog2(LOG_MAX + 1);
    // Exponent selected at reset (divide by 512)
    localparam int LOG_RST  = 9;

    // Field positions in the configuration word
    localparam int POS_EN    = 8;
    localparam int POS_AUTO  = 9;
    localparam int POS_BYP   = 10;
    localparam int POS_X1024 = 16;

    typedef struct packed {
        logic       x1024;
        logic       byp;
        logic       auto_stop;
        logic       en;
        logic [7:0] pow;
    } cfg_t;

    // Largest selected divisor wins; exponent 0 is pass-through.
    function automatic logic [LOG_W-1:0] sel_to_log2(
        input logic [7:0] pow,
        input logic       byp,
        input logic       x1024,
        input bit         has_x1024
    );
        logic [LOG_W-1:0] r;
        r = byp ? LOG_W'(0) : LOG_W'(1);
        for (int i = 0; i < 8; i++) begin
            if (pow[i]) r = LOG_W'(i + 2);
        end
        if (has_x1024 && x1024) r = LOG_W'(LOG_MAX);
        return r;
    endfunction

endpackage

// File: rtl/sdclk_cfg_reg.sv
module sdclk_cfg_reg
    import sdclk_pkg::*;
#(
    parameter bit HAS_DIV1024 = 1'b1,
    parameter int RD_W        = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en_i,
    input  logic [FIELD_W-1:0] wr_data_i,
    output cfg_t               cfg_o,
    output logic [RD_W-1:0]    rd_data_o
);

    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{x1024: 1'b0, byp: 1'b0, auto_stop: 1'b0, en: 1'b0, pow: 8'h80};
        end else if (wr_en_i) begin
            cfg_q.en        <= wr_data_i[POS_EN];
            cfg_q.auto_stop <= wr_data_i[POS_AUTO];
            // selector only moves while the clock is disabled
            if (!cfg_q.en) begin
                cfg_q.pow   <= wr_data_i[7:0];
                cfg_q.byp   <= wr_data_i[POS_BYP];
                cfg_q.x1024 <= HAS_DIV1024 ? wr_data_i[POS_X1024] : 1'b0;
            end
        end
    end

    always_comb begin
        rd_data_o            = '0;
        rd_data_o[7:0]       = cfg_q.pow;
        rd_data_o[POS_EN]    = cfg_q.en;
        rd_data_o[POS_AUTO]  = cfg_q.auto_stop;
        rd_data_o[POS_BYP]   = cfg_q.byp;
        rd_data_o[POS_X1024] = cfg_q.x1024;
    end

    assign cfg_o = cfg_q;

    // R6
    sel_lock_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_q.en |=> ($stable(cfg_q.pow) && $stable(cfg_q.byp) && $stable(cfg_q.x1024)));

    // R9
    no_x1024_chk: assert property (@(posedge clk) disable iff (rst)
        !HAS_DIV1024 |-> !rd_data_o[POS_X1024]);

endmodule

// File: rtl/sdclk_sel_decode.sv
module sdclk_sel_decode
    import sdclk_pkg::*;
#(
    parameter bit HAS_DIV1024 = 1'b1
) (
    input  logic [7:0]       pow_i,
    input  logic             byp_i,
    input  logic             x1024_i,
    output logic [LOG_W-1:0] log2_o
);

    always_comb begin
        log2_o = sel_to_log2(pow_i, byp_i, x1024_i, HAS_DIV1024);
        // R2
        dec_range_chk: assert (log2_o <= LOG_W'(LOG_MAX));
    end

endmodule

// File: rtl/sdclk_phase_gen.sv
module sdclk_phase_gen
    import sdclk_pkg::*;
#(
    parameter int CNT_W = LOG_MAX + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_req_i,
    input  logic [LOG_W-1:0] log2_i,
    output logic             lvl_o,
    output logic             rise_o,
    output logic             fall_o
);

    logic             run_q;
    logic             lvl_q;
    logic             rise_q;
    logic             fall_q;
    logic [LOG_W-1:0] k_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] full_m1;
    logic [CNT_W-1:0] half_m1;

    always_comb begin
        full_m1 = (CNT_W'(1) << k_q) - CNT_W'(1);
        half_m1 = (CNT_W'(1) << (k_q - LOG_W'(1))) - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            lvl_q  <= 1'b0;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
            cnt_q  <= '0;
            k_q    <= LOG_W'(LOG_RST);
        end else begin
            rise_q <= 1'b0;
            fall_q <= 1'b0;
            if (!run_q) begin
                // idle: latch the rate, start from a fresh low phase
                k_q   <= log2_i;
                cnt_q <= '0;
                lvl_q <= 1'b0;
                run_q <= run_req_i;
            end else if (!run_req_i && !lvl_q) begin
                run_q <= 1'b0;
                cnt_q <= '0;
            end else if (k_q == '0) begin
                rise_q <= 1'b1;
                fall_q <= 1'b1;
            end else if (cnt_q == half_m1) begin
                lvl_q  <= 1'b1;
                rise_q <= 1'b1;
                cnt_q  <= cnt_q + CNT_W'(1);
            end else if (cnt_q == full_m1) begin
                lvl_q  <= 1'b0;
                fall_q <= 1'b1;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign lvl_o  = lvl_q;
    assign rise_o = rise_q;
    assign fall_o = fall_q;

    // R3
    lvl_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lvl_q) |-> rise_q);

    // R6
    rate_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q && $past(run_q)) |-> $stable(k_q));

    // R7
    stop_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(run_q) |-> !lvl_q);

    // R8
    no_rise_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_req_i && !lvl_q) |=> (!rise_q && !lvl_q));

endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
    import sdclk_pkg::*;
#(
    parameter bit HAS_DIV1024 = 1'b1,
    parameter int RD_W        = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en_i,
    input  logic [FIELD_W-1:0] wr_data_i,
    output logic [RD_W-1:0]    rd_data_o,
    input  logic               busy_i,
    output logic               card_clk_o,
    output logic               card_rise_o,
    output logic               card_fall_o
);

    localparam int CNT_W = LOG_MAX + 1;

    cfg_t             cfg;
    logic [LOG_W-1:0] log2_sel;
    logic             run_req;

    sdclk_cfg_reg #(.HAS_DIV1024(HAS_DIV1024), .RD_W(RD_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .cfg_o     (cfg),
        .rd_data_o (rd_data_o)
    );

    sdclk_sel_decode #(.HAS_DIV1024(HAS_DIV1024)) u_dec (
        .pow_i   (cfg.pow),
        .byp_i   (cfg.byp),
        .x1024_i (cfg.x1024),
        .log2_o  (log2_sel)
    );

    assign run_req = cfg.en && (!cfg.auto_stop || busy_i);

    sdclk_phase_gen #(.CNT_W(CNT_W)) u_phase (
        .clk       (clk),
        .rst       (rst),
        .run_req_i (run_req),
        .log2_i    (log2_sel),
        .lvl_o     (card_clk_o),
        .rise_o    (card_rise_o),
        .fall_o    (card_fall_o)
    );

    // R7
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg.en && !card_clk_o) |=> !card_rise_o);

endmodule

// File: tb/sim_sdclk_gen.sv
module sim_sdclk_gen;

    localparam int NV = 15;
    localparam int VEC_CODE [NV] = '{'h0, 'h1, 'h2, 'h4, 'h8, 'h10, 'h20, 'h40, 'h80,
                                     'h10000, 'h400, 'h401, 'h81, 'h10400, 'h24};
    localparam int VEC_DIV  [NV] = '{2, 4, 8, 16, 32, 64, 128, 256, 512,
                                     1024, 1, 4, 512, 1024, 128};
    localparam int VEC_REQ  [NV] = '{2, 2, 2, 2, 2, 2, 2, 2, 2, 2, 5, 4, 4, 4, 4};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [16:0] wr_data = '0;
    logic        busy = 1'b0;
    logic [31:0] rd0, rd1;
    logic        ck0, ri0, fa0, ck1, ri1, fa1;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    sdclk_gen #(.HAS_DIV1024(1'b1)) u0 (
        .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd0),
        .busy_i(busy), .card_clk_o(ck0), .card_rise_o(ri0), .card_fall_o(fa0));

    sdclk_gen #(.HAS_DIV1024(1'b0)) u1 (
        .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd1),
        .busy_i(busy), .card_clk_o(ck1), .card_rise_o(ri1), .card_fall_o(fa1));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [16:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // From a negedge: wait for a rise strobe, then measure one full period
    task automatic measure(output int per, output int hi);
        int t = 0;
        while (!ri0 && t < 5000) begin
            @(negedge clk);
            t++;
        end
        per = 0;
        hi  = 0;
        do begin
            if (ck0) hi++;
            @(negedge clk);
            per++;
        end while (!ri0 && per < 5000);
    endtask

    task automatic count_rises(input bit which, input int cycles, output int n);
        n = 0;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            if (which ? ri1 : ri0) n++;
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int per, hi, n, h;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(rd0 == 32'h80, "R1", rd0, 32'h80);
        check({ck0, ri0, fa0} == 3'b000, "R1", {ck0, ri0, fa0}, 0);
        rst = 1'b0;
        count_rises(1'b0, 20, n);
        check(n == 0, "R7 disabled at reset", n, 0);

        // R2 R3 R4 R5: table of selector codes
        for (int i = 0; i < NV; i++) begin
            wr(17'(VEC_CODE[i] | 'h100));
            measure(per, hi);
            check(per == VEC_DIV[i], $sformatf("R%0d period code 0x%0h", VEC_REQ[i], VEC_CODE[i]),
                  per, VEC_DIV[i]);
            check(hi == VEC_DIV[i] / 2, $sformatf("R%0d high time (R3 R5) code 0x%0h",
                  VEC_REQ[i], VEC_CODE[i]), hi, VEC_DIV[i] / 2);
            wr(17'h0);
            repeat (1100) @(negedge clk);
        end

        // R10: unimplemented bits read zero
        wr(17'h0F800);
        check(rd0 == 32'h0, "R10", rd0, 0);

        // R6: selector locked while enabled
        wr(17'h100);
        wr(17'h101);
        check(rd0 == 32'h100, "R6 write while enabled", rd0, 32'h100);
        measure(per, hi);
        check(per == 2, "R6 rate kept", per, 2);
        wr(17'h001);
        check(rd0 == 32'h000, "R6 write that clears enable", rd0, 0);
        repeat (10) @(negedge clk);
        wr(17'h001);
        check(rd0 == 32'h001, "R6 write while disabled", rd0, 1);

        // R7: disable during a high phase of divide-by-8
        wr(17'h102);
        check(rd0 == 32'h102, "R7 setup", rd0, 32'h102);
        while (!ri0) @(negedge clk);
        wr_en = 1'b1;
        wr_data = 17'h002;
        h = 1;
        @(negedge clk);
        wr_en = 1'b0;
        while (ck0 && h < 100) begin
            h++;
            @(negedge clk);
        end
        check(h == 4, "R7 high phase completes", h, 4);
        count_rises(1'b0, 40, n);
        check(n == 0 && !ck0, "R7 no strobes after stop", n, 0);

        // R8: auto-stop with busy
        wr(17'h302);
        count_rises(1'b0, 40, n);
        check(n == 0 && !ck0, "R8 idle without busy", n, 0);
        busy = 1'b1;
        measure(per, hi);
        check(per == 8 && hi == 4, "R8 runs with busy", per, 8);
        busy = 1'b0;
        h = 0;
        while (ck0 && h < 100) begin
            h++;
            @(negedge clk);
        end
        check(h == 4, "R8 high phase completes after busy drop", h, 4);
        count_rises(1'b0, 40, n);
        check(n == 0 && !ck0, "R8 parked low", n, 0);
        busy = 1'b1;
        measure(per, hi);
        check(per == 8, "R8 restart", per, 8);
        // busy falls on the same cycle as a fall strobe
        while (!fa0) @(negedge clk);
        busy = 1'b0;
        count_rises(1'b0, 40, n);
        check(n == 0 && !ck0, "R8 busy drop at fall strobe", n, 0);

        // R9: instance without divide-by-1024
        wr(17'h0);
        repeat (20) @(negedge clk);
        wr(17'h10100);
        check(rd1 == 32'h100, "R9 bit16 absent", rd1, 32'h100);
        check(rd0 == 32'h10100, "R9 bit16 present", rd0, 32'h10100);
        repeat (4) @(negedge clk);
        count_rises(1'b1, 40, n);
        check(n == 20, "R9 divide by 2 without capability", n, 20);

        done = 1'b1;
        finish_run();
    end

endmodule